// File: doc/BRIEF.md
# Half-Bridge Gate Command Supervisor

This block sits between a multiphase controller's three-level PWM line and the gate drivers of one synchronous buck phase. The analog front end has already reduced the PWM pin, the driver supply and the die temperature to synchronized digital flags and a temperature code. From these the block decides, every clock, whether the high-side switch, the low-side switch or neither may conduct. It also raises a fault flag when the die overheats.

Five conditions gate the switching. The phase must be enabled, and it must have been enabled long enough to pass a fixed blanking interval. The driver supply must have cleared its power-on level and not since dropped below its lockout level. The die must not be in thermal shutdown. The PWM line must not have sat in its middle, undriven window for too long. A separate diode-emulation block may also veto the low side. An interlock with a programmable dead time sits at the output, so the two switches never conduct together. It also leaves a fixed gap between one switch turning off and the other turning on.

All delays are counted in cycles of a 100 MHz clock, and all are parameters. The defaults are a 300-cycle enable blanking, an 8-sample tri-state filter and a 4-cycle dead time. Temperature is an unsigned code at 1 °C per LSB. The shutdown threshold is 150 °C with a 25 °C hysteresis band.

Top module: `hb_gate_sup`

## Requirements
- R1: While rst_ni is low and right after reset, hs_gate_o, ls_gate_o and fault_o are all low.
- R2: When en_i is low, both gate outputs are low from the second clock edge after en_i is sampled low.
- R3: Every change of en_i restarts a blanking interval of HOLDOFF_CYC cycles during which both gates stay low. With PWM held high and all else ready, hs_gate_o rises at the (HOLDOFF_CYC+1)-th edge after the edge that samples en_i high.
- R4: Supply hysteresis. The gates stay low until vdd_por_i has been sampled high. After that, a supply between the two levels (both flags low) keeps the previous state. vdd_uvlo_i high forces both gates low until vdd_por_i is seen high again. Switching then resumes at the second edge, with no blanking.
- R5: PWM level is encoded as {pwm_hi_i,pwm_lo_i}. 2'b10 means high, and it turns the high side on and the low side off. 2'b01 means low, and it does the reverse. The command register follows the level one edge after it is sampled.
- R6: 2'b00 and 2'b11 form the middle (tri-state) window. If the window lasts more than TRI_HOLD_CYC consecutive samples, both gates turn off. A stay of TRI_HOLD_CYC samples or fewer leaves the gate state unchanged.
- R7: temp_i at or above OT_SET_C sets fault_o at the next edge, and both gates are low one edge later. A code below OT_SET_C never sets it.
- R8: fault_o stays set while temp_i is at or above OT_SET_C-OT_HYST_C (125 by default). It clears at the next edge once temp_i is below that value, and switching then resumes.
- R9: hs_gate_o and ls_gate_o are never high together. When one gate goes low, the opposite gate goes high DEAD_CYC+1 cycles later at the earliest.
- R10: dem_ls_off_i high forces ls_gate_o low at the next edge and has no effect on hs_gate_o.
- R11: fault_o is driven only by temperature. Lockout and disable never set it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | 100 MHz clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Phase enable, synchronized, low when undriven |
| pwm_hi_i | input | 1 | PWM above high threshold |
| pwm_lo_i | input | 1 | PWM below low threshold |
| vdd_por_i | input | 1 | Driver supply above power-on level |
| vdd_uvlo_i | input | 1 | Driver supply below lockout level |
| temp_i | input | TEMP_W | Die temperature code, 1 °C per LSB |
| dem_ls_off_i | input | 1 | Diode-emulation veto of the low side |
| hs_gate_o | output | 1 | High-side gate command |
| ls_gate_o | output | 1 | Low-side gate command |
| fault_o | output | 1 | Thermal shutdown flag |

## Verification
The assertions assume that every input is already synchronized to clk_i and changes at most once per cycle. They also assume that vdd_por_i and vdd_uvlo_i are never high together, because one physical supply cannot be both above the power-on level and below the lockout level. The stimulus drives every input on the falling clock edge and only ever sets one supply flag at a time. Each scenario waits for the dead-time counter to expire before it times a fresh turn-on.

// File: rtl/hb_gate_pkg.sv
package hb_gate_pkg;
  typedef enum logic [1:0] {
    CMD_OFF = 2'd0,
    CMD_HS  = 2'd1,
    CMD_LS  = 2'd2
  } gate_cmd_e;
endpackage

// File: rtl/hb_supply_gate.sv
module hb_supply_gate #(
  parameter int HOLDOFF_CYC = 300
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic vdd_por_i,
  input  logic vdd_uvlo_i,
  output logic run_o
);
  localparam int HW = (HOLDOFF_CYC > 0) ? $clog2(HOLDOFF_CYC + 1) : 1;
  localparam logic [HW-1:0] HLOAD = HW'(HOLDOFF_CYC);

  logic          vdd_ok_q, en_q;
  logic [HW-1:0] hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vdd_ok_q <= 1'b0;
      en_q     <= 1'b0;
      hold_q   <= '0;
    end else begin
      // lockout wins over power-on
      if (vdd_uvlo_i)     vdd_ok_q <= 1'b0;
      else if (vdd_por_i) vdd_ok_q <= 1'b1;
      en_q <= en_i;
      if (en_i != en_q)        hold_q <= HLOAD;
      else if (hold_q != '0)   hold_q <= hold_q - 1'b1;
    end
  end

  assign run_o = vdd_ok_q && en_q && (hold_q == '0);

  p_uvlo_lock_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vdd_uvlo_i |=> !run_o);
  p_blank_start_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !en_q) |=> !run_o);
  p_en_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !run_o);
endmodule

// File: rtl/hb_pwm_level.sv
module hb_pwm_level
  import hb_gate_pkg::*;
#(
  parameter int TRI_HOLD_CYC = 8
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      pwm_hi_i,
  input  logic      pwm_lo_i,
  output gate_cmd_e cmd_o
);
  localparam int TW = (TRI_HOLD_CYC > 0) ? $clog2(TRI_HOLD_CYC + 1) : 1;
  localparam logic [TW-1:0] TLIM = TW'(TRI_HOLD_CYC);

  logic          mid;
  logic [TW-1:0] mid_q;
  gate_cmd_e     cmd_q;

  assign mid = (pwm_hi_i == pwm_lo_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q <= CMD_OFF;
      mid_q <= '0;
    end else if (!mid) begin
      mid_q <= '0;
      cmd_q <= pwm_hi_i ? CMD_HS : CMD_LS;
    end else if (mid_q == TLIM) begin
      cmd_q <= CMD_OFF;
    end else begin
      mid_q <= mid_q + 1'b1;
    end
  end

  assign cmd_o = cmd_q;

  p_level_hs_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwm_hi_i && !pwm_lo_i) |=> (cmd_o == CMD_HS));
  p_level_ls_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pwm_hi_i && pwm_lo_i) |=> (cmd_o == CMD_LS));
  p_short_mid_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mid && mid_q != TLIM) |=> (cmd_o == $past(cmd_o)));
endmodule

// File: rtl/hb_thermal.sv
module hb_thermal #(
  parameter int TEMP_W     = 8,
  parameter int OT_SET_C   = 150,
  parameter int OT_HYST_C  = 25
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TEMP_W-1:0] temp_i,
  output logic              fault_o
);
  localparam logic [TEMP_W-1:0] T_SET = TEMP_W'(OT_SET_C);
  localparam logic [TEMP_W-1:0] T_CLR = TEMP_W'(OT_SET_C - OT_HYST_C);

  logic fault_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              fault_q <= 1'b0;
    else if (temp_i >= T_SET) fault_q <= 1'b1;
    else if (temp_i <  T_CLR) fault_q <= 1'b0;
  end

  assign fault_o = fault_q;

  p_ot_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (temp_i >= T_SET) |=> fault_o);
  p_ot_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fault_o && temp_i < T_SET) |=> !fault_o);
  p_ot_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_o && temp_i >= T_CLR) |=> fault_o);
endmodule

// File: rtl/hb_deadtime.sv
module hb_deadtime #(
  parameter int DEAD_CYC = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] want_i,   // [0] high side, [1] low side
  output logic [1:0] gate_o
);
  localparam int DW = (DEAD_CYC > 0) ? $clog2(DEAD_CYC + 1) : 1;
  localparam logic [DW-1:0] DLOAD = DW'(DEAD_CYC);

  logic [1:0]    gate_q, nxt;
  logic [DW-1:0] dt_q;
  logic          dt_zero;

  assign dt_zero = (dt_q == '0);

  for (genvar g = 0; g < 2; g++) begin : g_side
    // conflicting requests turn both off
    assign nxt[g] = want_i[g] && !want_i[1-g] &&
                    (gate_q[g] || (!gate_q[1-g] && dt_zero));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_q <= '0;
      dt_q   <= '0;
    end else begin
      gate_q <= nxt;
      if (|(gate_q & ~nxt)) dt_q <= DLOAD;
      else if (!dt_zero)    dt_q <= dt_q - 1'b1;
    end
  end

  assign gate_o = gate_q;

  p_no_overlap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(gate_o[0] && gate_o[1]));
  p_gap_hs_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gate_o[0]) |-> !$past(gate_o[1]));
  p_gap_ls_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gate_o[1]) |-> !$past(gate_o[0]));
endmodule

// File: rtl/hb_gate_sup.sv
module hb_gate_sup
  import hb_gate_pkg::*;
#(
  parameter int HOLDOFF_CYC  = 300,
  parameter int TRI_HOLD_CYC = 8,
  parameter int DEAD_CYC     = 4,
  parameter int TEMP_W       = 8,
  parameter int OT_SET_C     = 150,
  parameter int OT_HYST_C    = 25
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              pwm_hi_i,
  input  logic              pwm_lo_i,
  input  logic              vdd_por_i,
  input  logic              vdd_uvlo_i,
  input  logic [TEMP_W-1:0] temp_i,
  input  logic              dem_ls_off_i,
  output logic              hs_gate_o,
  output logic              ls_gate_o,
  output logic              fault_o
);
  logic      run, fault, allow;
  gate_cmd_e cmd;
  logic [1:0] want, gate;

  hb_supply_gate #(.HOLDOFF_CYC(HOLDOFF_CYC)) u_supply (
    .clk_i, .rst_ni, .en_i, .vdd_por_i, .vdd_uvlo_i, .run_o(run)
  );

  hb_pwm_level #(.TRI_HOLD_CYC(TRI_HOLD_CYC)) u_level (
    .clk_i, .rst_ni, .pwm_hi_i, .pwm_lo_i, .cmd_o(cmd)
  );

  hb_thermal #(.TEMP_W(TEMP_W), .OT_SET_C(OT_SET_C), .OT_HYST_C(OT_HYST_C)) u_thermal (
    .clk_i, .rst_ni, .temp_i, .fault_o(fault)
  );

  assign allow   = run && !fault;
  assign want[0] = allow && (cmd == CMD_HS);
  assign want[1] = allow && (cmd == CMD_LS) && !dem_ls_off_i;

  hb_deadtime #(.DEAD_CYC(DEAD_CYC)) u_dead (
    .clk_i, .rst_ni, .want_i(want), .gate_o(gate)
  );

  assign hs_gate_o = gate[0];
  assign ls_gate_o = gate[1];
  assign fault_o   = fault;

  p_fault_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |=> (!hs_gate_o && !ls_gate_o));
  p_dem_veto_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dem_ls_off_i |=> !ls_gate_o);
  p_disabled_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(en_i, 2) |-> (!hs_gate_o && !ls_gate_o));
endmodule

// File: tb/hb_gate_sup_bench.sv
module hb_gate_sup_bench;
  localparam int HOLD = 300;
  localparam int TRI  = 8;
  localparam int DEAD = 4;
  localparam int TW   = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic en = 1'b0, pwm_hi = 1'b0, pwm_lo = 1'b0, por = 1'b0, uvlo = 1'b0, dem = 1'b0;
  logic [TW-1:0] temp = 8'd25;
  logic hs, ls, flt;

  int n_chk = 0, n_bad = 0, n_overlap = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  hb_gate_sup #(
    .HOLDOFF_CYC(HOLD), .TRI_HOLD_CYC(TRI), .DEAD_CYC(DEAD),
    .TEMP_W(TW), .OT_SET_C(150), .OT_HYST_C(25)
  ) u_hb_gate_sup (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .pwm_hi_i(pwm_hi), .pwm_lo_i(pwm_lo),
    .vdd_por_i(por), .vdd_uvlo_i(uvlo), .temp_i(temp), .dem_ls_off_i(dem),
    .hs_gate_o(hs), .ls_gate_o(ls), .fault_o(flt)
  );

  always @(negedge clk) if (rst_ni && hs && ls) n_overlap++;

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic set_pwm(input bit h, input bit l);
    pwm_hi = h; pwm_lo = l;
  endtask

  task automatic t_reset;
    step(2);
    chk("R1", "hs in reset", hs, 0);
    chk("R1", "ls in reset", ls, 0);
    chk("R1", "fault in reset", flt, 0);
    rst_ni = 1'b1;
    step(2);
    chk("R1", "hs after reset", hs, 0);
    chk("R1", "fault after reset", flt, 0);
  endtask

  task automatic t_power_up;
    set_pwm(1, 0);
    por = 1'b1;
    step(5);
    chk("R2", "hs with enable low", hs, 0);
    chk("R2", "ls with enable low", ls, 0);
  endtask

  task automatic t_blanking;
    en = 1'b1;
    step(HOLD + 1);
    chk("R3", "hs at end of blanking", hs, 0);
    step(1);
    chk("R3", "hs after blanking", hs, 1);
    chk("R5", "ls while pwm high", ls, 0);
  endtask

  task automatic t_switch;
    set_pwm(0, 1);
    step(2);
    chk("R5", "hs after pwm low", hs, 0);
    step(DEAD);
    chk("R9", "ls inside dead time", ls, 0);
    step(1);
    chk("R9", "ls after dead time", ls, 1);
    set_pwm(1, 0);
    step(2);
    chk("R5", "ls after pwm high", ls, 0);
    step(DEAD);
    chk("R9", "hs inside dead time", hs, 0);
    step(1);
    chk("R9", "hs after dead time", hs, 1);
  endtask

  task automatic t_tristate;
    set_pwm(0, 0);
    step(TRI);
    chk("R6", "hs during short mid", hs, 1);
    set_pwm(1, 0);
    step(3);
    chk("R6", "hs after short mid", hs, 1);
    set_pwm(1, 1);
    step(TRI + 1);
    chk("R6", "hs at mid limit", hs, 1);
    step(1);
    chk("R6", "hs after long mid", hs, 0);
    chk("R6", "ls after long mid", ls, 0);
    set_pwm(1, 0);
    step(DEAD + 3);
    chk("R6", "hs on recovery", hs, 1);
  endtask

  task automatic t_thermal;
    temp = 8'd149;
    step(2);
    chk("R7", "fault below threshold", flt, 0);
    temp = 8'd150;
    step(1);
    chk("R7", "fault at threshold", flt, 1);
    step(1);
    chk("R7", "hs in fault", hs, 0);
    temp = 8'd130;
    step(5);
    chk("R8", "fault inside band", flt, 1);
    chk("R8", "hs inside band", hs, 0);
    temp = 8'd125;
    step(3);
    chk("R8", "fault at clear level", flt, 1);
    temp = 8'd124;
    step(1);
    chk("R8", "fault below clear level", flt, 0);
    step(1);
    chk("R8", "hs after clear", hs, 1);
    temp = 8'd25;
  endtask

  task automatic t_dem;
    set_pwm(0, 1);
    step(DEAD + 4);
    chk("R10", "ls before veto", ls, 1);
    dem = 1'b1;
    step(1);
    chk("R10", "ls vetoed", ls, 0);
    chk("R10", "hs while ls vetoed", hs, 0);
    dem = 1'b0;
    step(DEAD + 3);
    chk("R10", "ls after veto", ls, 1);
    dem = 1'b1;
    set_pwm(1, 0);
    step(DEAD + 4);
    chk("R10", "hs with veto", hs, 1);
    dem = 1'b0;
    step(2);
  endtask

  task automatic t_uvlo;
    por = 1'b0;
    step(5);
    chk("R4", "hs between levels", hs, 1);
    uvlo = 1'b1;
    step(2);
    chk("R4", "hs in lockout", hs, 0);
    chk("R11", "fault in lockout", flt, 0);
    uvlo = 1'b0;
    step(5);
    chk("R4", "hs rising between levels", hs, 0);
    por = 1'b1;
    step(2);
    chk("R4", "hs after power-on", hs, 1);
  endtask

  task automatic t_disable;
    en = 1'b0;
    step(2);
    chk("R2", "hs disabled", hs, 0);
    chk("R2", "ls disabled", ls, 0);
    chk("R11", "fault disabled", flt, 0);
    step(20);
    en = 1'b1;
    step(HOLD + 1);
    chk("R3", "hs re-enable blanking", hs, 0);
    step(1);
    chk("R3", "hs after re-enable", hs, 1);
  endtask

  task automatic finish_run;
    done = 1'b1;
    chk("R9", "overlap cycles", n_overlap, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    t_reset();
    t_power_up();
    t_blanking();
    t_switch();
    t_tristate();
    t_thermal();
    t_dem();
    t_uvlo();
    t_disable();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule